// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector with Way Locking

This block keeps the replacement state for every set of an N-way set-associative cache and names the way to evict on a miss. Each way of each set carries a single use bit instead of a full recency ordering. The bit is raised whenever the way is touched, either by a hit or by a fill. When a touch would leave no unlocked way of that set with a clear bit, every use bit of the set is cleared at once.

Ways can be withheld from replacement in two ways. A per-set pin mask lets software keep chosen contents resident. The pin mask can be rewritten, but it is limited to a maximum number of pinned ways, so that some ways are always left for normal replacement. A per-set fault mask marks ways whose tag or data storage is broken. Fault bits only accumulate and are never cleared, so an affected set keeps working as an (N-1)-way set, or narrower.

The victim for the set on `accSet` is computed combinationally from the current state. Any change to the state takes effect on the next rising clock edge. Tag comparison, data storage and the refill sequence belong to the surrounding cache.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset, every use bit, pin bit and fault bit is zero. Every set then reports `victimWay` = 0 and `noVictim` = 0.
- R2: An access with `accValid`=1 and `accIsFill`=0 sets the use bit of way `accHitWay` in set `accSet`.
- R3: An access with `accValid`=1 and `accIsFill`=1 sets the use bit of the way that `victimWay` showed for that set during the access cycle.
- R4: The victim is the lowest-numbered way that is unlocked and has a clear use bit. If every unlocked way has its use bit set, the victim is the lowest-numbered unlocked way.
- R5: If, after an access, every unlocked way of the set would have its use bit set, all use bits of that set are cleared instead, including the bits of locked ways.
- R6: A way counts as locked when its pin bit or its fault bit is 1. A locked way is never reported as the victim.
- R7: A write with `cfgWrEn`=1 ORs `cfgFaultMask` into the fault mask of set `cfgSet`. A fault bit, once set, stays set until reset.
- R8: A write with `cfgWrEn`=1 replaces the pin mask of set `cfgSet` with `cfgPinMask`. If `cfgPinMask` has more than MAX_PIN bits set (6 by default), the pin mask is left unchanged.
- R9: When every way of set `accSet` is locked, `noVictim` is 1 and `victimWay` is 0. An access to that set then leaves its use bits unchanged.
- R10: The outputs follow the state that existed before the current cycle. The effect of an access or a configuration write appears on the outputs only after the next rising edge.
- R11: An access or configuration write to one set leaves the state of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | Access strobe (a hit or a fill) |
| accIsFill | input | 1 | 1: the fill goes to the victim way; 0: hit on `accHitWay` |
| accSet | input | SET_W | Set that is accessed and whose victim is reported |
| accHitWay | input | WAY_W | Way that hit |
| cfgWrEn | input | 1 | Write strobe for the lock masks |
| cfgSet | input | SET_W | Set whose masks are written |
| cfgPinMask | input | NUM_WAYS | New pin mask (replaces the old one) |
| cfgFaultMask | input | NUM_WAYS | Fault bits to add (ORed in) |
| victimWay | output | WAY_W | Way to replace in set `accSet` |
| noVictim | output | 1 | Every way of set `accSet` is locked |

## Verification
The hardest case to reach from the ports is a set whose ways are all locked while accesses keep arriving, followed by a partial unlock. Only that sequence shows that the blocked accesses left the hidden use bits alone. The stimulus builds this case on purpose: it pins six ways, marks the other two as faulty, hits the set, and then clears the pin mask so that the victim shows the use bits. A second directed sequence mixes locked and unlocked ways so that the clear-all fires after fewer than N touches. After these, seeded random accesses and occasional mask writes are checked every cycle against a bench model of all sets.

// File: rtl/nru_pkg.sv
package nru_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic useUpd;   // apply a use-bit update for updSet/updWay
    logic pinWr;    // replace the pin mask of cfgSet
    logic faultWr;  // OR new fault bits into cfgSet
  } ctrlStrobe_t;

endpackage

// File: rtl/nru_ctrl.sv
module nru_ctrl
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter int MAX_PIN  = 6,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                accValid,
  input  logic                accIsFill,
  input  logic [SET_W-1:0]    accSet,
  input  logic [WAY_W-1:0]    accHitWay,
  input  logic                cfgWrEn,
  input  logic [NUM_WAYS-1:0] cfgPinMask,
  input  logic                noVictim,
  input  logic [WAY_W-1:0]    victimWay,
  output ctrlStrobe_t         strb,
  output logic [SET_W-1:0]    updSet,
  output logic [WAY_W-1:0]    updWay
);

  logic pinOk;

  always_comb begin
    pinOk = ($countones(cfgPinMask) <= MAX_PIN);
    strb.useUpd  = accValid && !noVictim;   // fully locked set: no update
    strb.pinWr   = cfgWrEn && pinOk;
    strb.faultWr = cfgWrEn;
    updSet       = accSet;
    updWay       = accIsFill ? victimWay : accHitWay;
  end

endmodule

// File: rtl/nru_dpath.sv
module nru_dpath
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [SET_W-1:0]    updSet,
  input  logic [WAY_W-1:0]    updWay,
  input  logic [SET_W-1:0]    cfgSet,
  input  logic [NUM_WAYS-1:0] cfgPinMask,
  input  logic [NUM_WAYS-1:0] cfgFaultMask,
  input  logic [SET_W-1:0]    accSet,
  output logic [NUM_WAYS-1:0] curUse,
  output logic [NUM_WAYS-1:0] curLock,
  output logic [NUM_WAYS-1:0] curPin,
  output logic [NUM_WAYS-1:0] curFault,
  output logic [WAY_W-1:0]    victimWay,
  output logic                noVictim
);

  logic [NUM_WAYS-1:0] useArr   [NUM_SETS];
  logic [NUM_WAYS-1:0] pinArr   [NUM_SETS];
  logic [NUM_WAYS-1:0] faultArr [NUM_SETS];
  logic [NUM_WAYS-1:0] nextUse;

  // Next use bits for the set being updated (clear-all over unlocked ways)
  always_comb begin
    logic [NUM_WAYS-1:0] merged;
    logic [NUM_WAYS-1:0] lockU;
    merged  = useArr[updSet] | (NUM_WAYS'(1) << updWay);
    lockU   = pinArr[updSet] | faultArr[updSet];
    nextUse = ((merged | lockU) == '1) ? '0 : merged;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [NUM_WAYS-1:0] useR, pinR, faultR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        useR   <= '0;
        pinR   <= '0;
        faultR <= '0;
      end else begin
        if (strb.useUpd && updSet == SET_W'(s)) useR <= nextUse;
        if (strb.pinWr && cfgSet == SET_W'(s)) pinR <= cfgPinMask;
        if (strb.faultWr && cfgSet == SET_W'(s)) faultR <= faultR | cfgFaultMask;
      end
    end
    assign useArr[s]   = useR;
    assign pinArr[s]   = pinR;
    assign faultArr[s] = faultR;
  end

  // Victim for the set on accSet: lowest unlocked clear way, else lowest unlocked
  always_comb begin
    logic [NUM_WAYS-1:0] cand;
    curUse   = useArr[accSet];
    curPin   = pinArr[accSet];
    curFault = faultArr[accSet];
    curLock  = curPin | curFault;
    cand     = ~curUse & ~curLock;
    if (cand == '0) cand = ~curLock;
    victimWay = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (cand[i]) victimWay = WAY_W'(i);
    end
    noVictim = (cand == '0);
  end

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter int MAX_PIN  = 6,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic                accIsFill,
  input  logic [SET_W-1:0]    accSet,
  input  logic [WAY_W-1:0]    accHitWay,
  input  logic                cfgWrEn,
  input  logic [SET_W-1:0]    cfgSet,
  input  logic [NUM_WAYS-1:0] cfgPinMask,
  input  logic [NUM_WAYS-1:0] cfgFaultMask,
  output logic [WAY_W-1:0]    victimWay,
  output logic                noVictim
);

  ctrlStrobe_t         strb;
  logic [SET_W-1:0]    updSet;
  logic [WAY_W-1:0]    updWay;
  logic [NUM_WAYS-1:0] curUse, curLock, curPin, curFault;

  nru_ctrl #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .MAX_PIN(MAX_PIN)) u_ctrl (
    .accValid   (accValid),
    .accIsFill  (accIsFill),
    .accSet     (accSet),
    .accHitWay  (accHitWay),
    .cfgWrEn    (cfgWrEn),
    .cfgPinMask (cfgPinMask),
    .noVictim   (noVictim),
    .victimWay  (victimWay),
    .strb       (strb),
    .updSet     (updSet),
    .updWay     (updWay)
  );

  nru_dpath #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .updSet       (updSet),
    .updWay       (updWay),
    .cfgSet       (cfgSet),
    .cfgPinMask   (cfgPinMask),
    .cfgFaultMask (cfgFaultMask),
    .accSet       (accSet),
    .curUse       (curUse),
    .curLock      (curLock),
    .curPin       (curPin),
    .curFault     (curFault),
    .victimWay    (victimWay),
    .noVictim     (noVictim)
  );

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 16,
  parameter int MAX_PIN  = 6,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                accValid,
  input logic                accIsFill,
  input logic [SET_W-1:0]    accSet,
  input logic [WAY_W-1:0]    victimWay,
  input logic                noVictim,
  input ctrlStrobe_t         strb,
  input logic [WAY_W-1:0]    updWay,
  input logic [NUM_WAYS-1:0] curUse,
  input logic [NUM_WAYS-1:0] curLock,
  input logic [NUM_WAYS-1:0] curPin,
  input logic [NUM_WAYS-1:0] curFault
);

  // R6: a reported victim is never locked
  p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    !noVictim |-> !curLock[victimWay]);

  // R4: a clear unlocked way is preferred when one exists
  p_victim_clear_pref_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!noVictim && ((~curUse & ~curLock) != '0)) |-> !curUse[victimWay]);

  // R3: a fill updates exactly the reported victim way
  p_fill_hits_victim_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsFill && !noVictim) |-> (strb.useUpd && updWay == victimWay));

  // R9: a fully locked set receives no use-bit update
  p_locked_set_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && noVictim) |-> !strb.useUpd);

  // R8: a pin mask never holds more than MAX_PIN ways
  p_pin_limit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(curPin) <= MAX_PIN);

  // R7: fault bits of a set that stays selected never drop
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accSet == $past(accSet)) |-> (($past(curFault) & ~curFault) == '0));

endmodule

bind nru_victim_sel nru_victim_sel_chk #(
  .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .MAX_PIN(MAX_PIN)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .accIsFill (accIsFill),
  .accSet    (accSet),
  .victimWay (victimWay),
  .noVictim  (noVictim),
  .strb      (strb),
  .updWay    (updWay),
  .curUse    (curUse),
  .curLock   (curLock),
  .curPin    (curPin),
  .curFault  (curFault)
);

// File: tb/nru_victim_sel_bench.sv
`timescale 1ns/1ps
module nru_victim_sel_bench;

  localparam int NW = 8;
  localparam int NS = 16;
  localparam int MP = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accValid = 1'b0, accIsFill = 1'b0;
  logic [3:0] accSet = '0;
  logic [2:0] accHitWay = '0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgSet = '0;
  logic [7:0] cfgPinMask = '0, cfgFaultMask = '0;
  logic [2:0] victimWay;
  logic       noVictim;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] useM [NS];
  logic [7:0] pinM [NS];
  logic [7:0] faultM [NS];

  always #2 clk = ~clk;   // 250 MHz

  nru_victim_sel u_nru_victim_sel (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIsFill(accIsFill),
    .accSet(accSet), .accHitWay(accHitWay), .cfgWrEn(cfgWrEn), .cfgSet(cfgSet),
    .cfgPinMask(cfgPinMask), .cfgFaultMask(cfgFaultMask),
    .victimWay(victimWay), .noVictim(noVictim)
  );

  function automatic logic [7:0] lockOf(int s);
    return pinM[s] | faultM[s];
  endfunction

  function automatic bit expNoVictim(int s);
    return lockOf(s) == 8'hFF;
  endfunction

  function automatic int expVictim(int s);
    logic [7:0] free;
    if (expNoVictim(s)) return 0;
    free = ~useM[s] & ~lockOf(s);
    if (free == 8'h00) free = ~lockOf(s);
    for (int i = 0; i < NW; i++) if (free[i]) return i;
    return 0;
  endfunction

  task automatic check(input string tag);
    int ev;
    bit en;
    ev = expVictim(int'(accSet));
    en = expNoVictim(int'(accSet));
    nChecks++;
    if (victimWay !== 3'(ev) || noVictim !== en) begin
      nFails++;
      $display("FAIL %s set=%0d victimWay=%0d noVictim=%0b expected victimWay=%0d noVictim=%0b",
               tag, accSet, victimWay, noVictim, ev, en);
    end
  endtask

  // One cycle: drive, check outputs before the edge, advance the model
  task automatic step(input bit v, input bit fill, input int s, input int w,
                      input bit cw, input int cs, input logic [7:0] pin,
                      input logic [7:0] flt, input string tag);
    logic [7:0] merged;
    int way;
    @(negedge clk);
    accValid = v; accIsFill = fill; accSet = 4'(s); accHitWay = 3'(w);
    cfgWrEn = cw; cfgSet = 4'(cs); cfgPinMask = pin; cfgFaultMask = flt;
    #1;
    check(tag);
    if (v && !expNoVictim(s)) begin
      way = fill ? expVictim(s) : w;
      merged = useM[s] | (8'h01 << way);
      useM[s] = ((merged | lockOf(s)) == 8'hFF) ? 8'h00 : merged;
    end
    if (cw) begin
      if ($countones(pin) <= MP) pinM[cs] = pin;
      faultM[cs] = faultM[cs] | flt;
    end
  endtask

  task automatic probe(input int s, input string tag);
    step(0, 0, s, 0, 0, 0, 8'h00, 8'h00, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    for (int s = 0; s < NS; s++) begin useM[s] = '0; pinM[s] = '0; faultM[s] = '0; end
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: reset state across all sets
    for (int s = 0; s < NS; s++) probe(s, "R1 reset");

    // R2, R10: hits walk the victim up; value before the edge is the old one
    for (int w = 0; w < 7; w++) begin
      step(1, 0, 0, w, 0, 0, 8'h00, 8'h00, "R10 pre-edge");
      probe(0, "R2 hit sets bit");
    end
    // R5: last clear way touched -> all clear, victim back to 0
    step(1, 0, 0, 7, 0, 0, 8'h00, 8'h00, "R4 last clear way");
    probe(0, "R5 clear-all");
    // R11: set 4 untouched by set 0 activity
    probe(4, "R11 other set");

    // R6, R8: pin six ways in set 1, then try seven
    step(0, 0, 1, 0, 1, 1, 8'h3F, 8'h00, "R6 pre");
    probe(1, "R6 pinned skipped");
    step(0, 0, 1, 0, 1, 1, 8'h7F, 8'h00, "R8 pre");
    probe(1, "R8 over-limit pin ignored");
    // R5 with locks: two unlocked ways, fill twice -> clear-all
    step(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R3 fill");
    probe(1, "R3 fill set victim bit");
    step(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R3 fill");
    probe(1, "R5 clear-all over unlocked");

    // R7: fault way 0 of set 2, writing zero cannot clear it
    step(0, 0, 2, 0, 1, 2, 8'h00, 8'h01, "R7 pre");
    step(0, 0, 2, 0, 1, 2, 8'h00, 8'h00, "R7 fault set");
    probe(2, "R7 fault sticky");

    // R9: fully lock set 3, hit it, then unpin and confirm use bits untouched
    step(0, 0, 3, 0, 1, 3, 8'h3F, 8'hC0, "R9 pre");
    probe(3, "R9 all locked");
    step(1, 0, 3, 0, 0, 0, 8'h00, 8'h00, "R9 locked hit");
    step(1, 1, 3, 0, 0, 0, 8'h00, 8'h00, "R9 locked fill");
    step(0, 0, 3, 0, 1, 3, 8'h00, 8'h00, "R9 unpin");
    probe(3, "R9 state undisturbed");

    // Random mix: accesses and occasional mask writes on all sets
    for (int n = 0; n < 4000; n++) begin
      int s, w, cs;
      bit v, f, cw;
      logic [7:0] pin, flt;
      s  = int'($urandom % NS);
      w  = int'($urandom % NW);
      v  = ($urandom % 4) != 0;
      f  = ($urandom % 2) != 0;
      cw = ($urandom % 12) == 0;
      cs = int'($urandom % NS);
      pin = 8'($urandom);
      flt = (($urandom % 10) == 0) ? (8'h01 << ($urandom % NW)) : 8'h00;
      step(v, f, s, w, cw, cs, pin, flt, "R4 random");
    end
    for (int s = 0; s < NS; s++) probe(s, "R11 final sweep");

    finish_run();
  end

endmodule